// File: doc/BRIEF.md
# Fixed-Point Chaotic Oscillator Integrator

This block advances a three-variable piecewise-linear chaotic oscillator in signed fixed-point arithmetic. Three state words (x, y, z) are each held in an accumulator. On every accepted step the block adds a scaled derivative to each accumulator, which is one forward-Euler step. The derivative of x passes through a three-segment nonlinearity of x whose two slopes are programmable. Seven words form the key: three starting values and four coefficients (alpha, beta, m0 and m1). A single load strobe captures all seven.

The new state leaves the block as an output stream. `out_valid` rises the cycle after a step is taken and marks the word on `x_out`, `y_out` and `z_out` as a fresh sample. While `out_valid` is high and `out_ready` is low, the sample is held and step requests are refused. A new step can be accepted in the same cycle in which the consumer takes the current sample. Every arithmetic operation clamps to the range of the number format. A sticky flag records that clamping took place at least once since the last load.

Top module: `chaos_euler_core`

## Requirements
- R1: After reset, all three state outputs are 0, and `out_valid` and `sat_flag` are 0.
- R2: A cycle with `key_load`=1 makes the next cycle show `key_x0`/`key_y0`/`key_z0` on the state outputs, latches alpha, beta, m0 and m1, and clears `out_valid` and `sat_flag`. `key_load` takes priority over `step_en`.
- R3: Every word is a 32-bit two's-complement number with 25 fraction bits (1.0 = 2^25). A product is the full 64-bit product shifted right arithmetically by 25, which rounds toward minus infinity. The step size is 2^-7: each increment is the derivative shifted right arithmetically by 7.
- R4: The nonlinearity f(x) has three segments. For x > +1.0 it is m1*x + (m0-m1). For x < -1.0 it is m1*x - (m0-m1). For -1.0 <= x <= +1.0 it is m0*x.
- R5: One step computes dx = alpha*((y-x)-f), dy = (x-y)+z and dz = 0-(beta*y), each from the current state. Each state word then becomes itself plus its increment.
- R6: Every add, subtract and multiply clamps to [-2^31, 2^31-1]. `sat_flag` is set after any step in which an operation whose result is used clamped. It stays set until the next load.
- R7: A step is accepted when `step_en`=1, `key_load`=0, and either `out_valid`=0 or `out_ready`=1. The next cycle shows `out_valid`=1 and the new state.
- R8: While `out_valid`=1 and `out_ready`=0 (and no load), `step_en` is ignored: `out_valid` and the state outputs hold.
- R9: When `out_valid`=1 and `out_ready`=1 with no step and no load, `out_valid` is 0 in the next cycle.
- R10: In a cycle with no accepted step and no load, the state outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Capture all seven key words |
| key_x0 | input | 32 | Starting value of x |
| key_y0 | input | 32 | Starting value of y |
| key_z0 | input | 32 | Starting value of z |
| key_alpha | input | 32 | Coefficient alpha |
| key_beta | input | 32 | Coefficient beta |
| key_m0 | input | 32 | Inner-segment slope m0 |
| key_m1 | input | 32 | Outer-segment slope m1 |
| step_en | input | 1 | Step request |
| out_ready | input | 1 | Consumer accepts the current sample |
| out_valid | output | 1 | State outputs carry a fresh sample |
| x_out | output | 32 | State x |
| y_out | output | 32 | State y |
| z_out | output | 32 | State z |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The hardest situations to reach are clamping, and values of x lying exactly on or one step beside a segment edge. A free-running trajectory meets these only by chance. The bench therefore loads hand-picked keys: x0 exactly at -2.0, 0.5 and 2.0, and large y0 with large alpha so that a product overflows. It checks these against literal expected words as well as against its own model. Back-pressure is exercised by a pseudo-random pattern on `step_en` and `out_ready` over thousands of cycles, which produces stalls, steps taken in the same cycle as a handshake, and idle gaps. Every clock is compared with a behavioural integer model.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FRAC_W   = 25;
  localparam int unsigned DT_SHIFT = 7;
  localparam int unsigned N_LANES  = 3;

  typedef enum logic [1:0] {
    SEG_MID  = 2'd0,
    SEG_HIGH = 2'd1,
    SEG_LOW  = 2'd2
  } pwl_seg_e;
endpackage

// File: rtl/chaos_addq.sv
module chaos_addq #(
  parameter int unsigned W = chaos_pkg::WORD_W
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sub,
  output logic signed [W-1:0] y,
  output logic                ovf
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;

  always_comb begin
    if (sub) wide = {a[W-1], a} - {b[W-1], b};
    else     wide = {a[W-1], a} + {b[W-1], b};
    ovf = (wide[W] != wide[W-1]);
    if (!ovf)        y = wide[W-1:0];
    else if (wide[W]) y = MINV;
    else             y = MAXV;
  end
endmodule

// File: rtl/chaos_mulq.sv
module chaos_mulq #(
  parameter int unsigned W    = chaos_pkg::WORD_W,
  parameter int unsigned FRAC = chaos_pkg::FRAC_W
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y,
  output logic                ovf
);
  localparam int unsigned PW = 2 * W;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic        [W:0]    hi;

  always_comb begin
    prod   = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    scaled = prod >>> FRAC;
    hi     = scaled[PW-1:W-1];
    ovf    = !((&hi) || (~|hi));
    if (!ovf)             y = scaled[W-1:0];
    else if (scaled[PW-1]) y = MINV;
    else                  y = MAXV;
  end
endmodule

// File: rtl/chaos_pwl.sv
module chaos_pwl #(
  parameter int unsigned W    = chaos_pkg::WORD_W,
  parameter int unsigned FRAC = chaos_pkg::FRAC_W
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] m0,
  input  logic signed [W-1:0] m1,
  output logic signed [W-1:0] f,
  output logic                ovf
);
  import chaos_pkg::*;

  localparam logic signed [W-1:0] POS_ONE = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
  localparam logic signed [W-1:0] NEG_ONE = -POS_ONE;

  pwl_seg_e seg;
  logic signed [W-1:0] outer_x, inner_x, gap, outer_f;
  logic outer_ovf, inner_ovf, gap_ovf, sum_ovf;

  always_comb begin
    if (x > POS_ONE)      seg = SEG_HIGH;
    else if (x < NEG_ONE) seg = SEG_LOW;
    else                  seg = SEG_MID;
  end

  chaos_mulq #(.W(W), .FRAC(FRAC)) u_outer (.a(m1), .b(x), .y(outer_x), .ovf(outer_ovf));
  chaos_mulq #(.W(W), .FRAC(FRAC)) u_inner (.a(m0), .b(x), .y(inner_x), .ovf(inner_ovf));
  chaos_addq #(.W(W)) u_gap (.a(m0), .b(m1), .sub(1'b1), .y(gap), .ovf(gap_ovf));
  chaos_addq #(.W(W)) u_sum (.a(outer_x), .b(gap), .sub(seg == SEG_LOW),
                             .y(outer_f), .ovf(sum_ovf));

  always_comb begin
    if (seg == SEG_MID) begin
      f   = inner_x;
      ovf = inner_ovf;
    end else begin
      f   = outer_f;
      ovf = outer_ovf | gap_ovf | sum_ovf;
    end
  end
endmodule

// File: rtl/chaos_deriv.sv
module chaos_deriv #(
  parameter int unsigned W    = chaos_pkg::WORD_W,
  parameter int unsigned FRAC = chaos_pkg::FRAC_W
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic signed [W-1:0] z,
  input  logic signed [W-1:0] alpha,
  input  logic signed [W-1:0] beta,
  input  logic signed [W-1:0] m0,
  input  logic signed [W-1:0] m1,
  output logic signed [W-1:0] dx,
  output logic signed [W-1:0] dy,
  output logic signed [W-1:0] dz,
  output logic                ovf
);
  logic signed [W-1:0] fx, yx, inner, xy, by;
  logic [7:0] o;

  chaos_pwl  #(.W(W), .FRAC(FRAC)) u_pwl (.x(x), .m0(m0), .m1(m1), .f(fx), .ovf(o[0]));

  chaos_addq #(.W(W)) u_yx    (.a(y),  .b(x),  .sub(1'b1), .y(yx),    .ovf(o[1]));
  chaos_addq #(.W(W)) u_inner (.a(yx), .b(fx), .sub(1'b1), .y(inner), .ovf(o[2]));
  chaos_mulq #(.W(W), .FRAC(FRAC)) u_ax (.a(alpha), .b(inner), .y(dx), .ovf(o[3]));

  chaos_addq #(.W(W)) u_xy (.a(x),  .b(y), .sub(1'b1), .y(xy), .ovf(o[4]));
  chaos_addq #(.W(W)) u_dy (.a(xy), .b(z), .sub(1'b0), .y(dy), .ovf(o[5]));

  chaos_mulq #(.W(W), .FRAC(FRAC)) u_by (.a(beta), .b(y), .y(by), .ovf(o[6]));
  chaos_addq #(.W(W)) u_dz (.a('0), .b(by), .sub(1'b1), .y(dz), .ovf(o[7]));

  assign ovf = |o;
endmodule

// File: rtl/chaos_integ.sv
module chaos_integ #(
  parameter int unsigned W     = chaos_pkg::WORD_W,
  parameter int unsigned LANES = chaos_pkg::N_LANES,
  parameter int unsigned SHIFT = chaos_pkg::DT_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                adv,
  input  logic signed [W-1:0] init_v  [LANES],
  input  logic signed [W-1:0] rate_v  [LANES],
  output logic signed [W-1:0] state_v [LANES],
  output logic                ovf
);
  logic [LANES-1:0] lane_ovf;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [W-1:0] acc, inc, nxt;

    assign inc = rate_v[g] >>> SHIFT;

    chaos_addq #(.W(W)) u_acc (.a(acc), .b(inc), .sub(1'b0), .y(nxt), .ovf(lane_ovf[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (load) acc <= init_v[g];
      else if (adv)  acc <= nxt;
    end

    assign state_v[g] = acc;
  end

  assign ovf = |lane_ovf;
endmodule

// File: rtl/chaos_euler_core.sv
module chaos_euler_core #(
  parameter int unsigned W        = chaos_pkg::WORD_W,
  parameter int unsigned FRAC     = chaos_pkg::FRAC_W,
  parameter int unsigned DT_SHIFT = chaos_pkg::DT_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_load,
  input  logic signed [W-1:0] key_x0,
  input  logic signed [W-1:0] key_y0,
  input  logic signed [W-1:0] key_z0,
  input  logic signed [W-1:0] key_alpha,
  input  logic signed [W-1:0] key_beta,
  input  logic signed [W-1:0] key_m0,
  input  logic signed [W-1:0] key_m1,
  input  logic                step_en,
  input  logic                out_ready,
  output logic                out_valid,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out,
  output logic                sat_flag
);
  localparam int unsigned LANES = 3;

  logic signed [W-1:0] p_alpha, p_beta, p_m0, p_m1;
  logic signed [W-1:0] init_a [LANES];
  logic signed [W-1:0] rate_a [LANES];
  logic signed [W-1:0] st_a   [LANES];
  logic signed [W-1:0] dx, dy, dz;
  logic deriv_ovf, integ_ovf, accept, vld, flag;

  assign accept = step_en && !key_load && (!vld || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_alpha <= '0;
      p_beta  <= '0;
      p_m0    <= '0;
      p_m1    <= '0;
      vld     <= 1'b0;
      flag    <= 1'b0;
    end else if (key_load) begin
      p_alpha <= key_alpha;
      p_beta  <= key_beta;
      p_m0    <= key_m0;
      p_m1    <= key_m1;
      vld     <= 1'b0;
      flag    <= 1'b0;
    end else if (accept) begin
      vld  <= 1'b1;
      flag <= flag | deriv_ovf | integ_ovf;
    end else if (vld && out_ready) begin
      vld <= 1'b0;
    end
  end

  assign init_a[0] = key_x0;
  assign init_a[1] = key_y0;
  assign init_a[2] = key_z0;
  assign rate_a[0] = dx;
  assign rate_a[1] = dy;
  assign rate_a[2] = dz;

  chaos_deriv #(.W(W), .FRAC(FRAC)) u_deriv (
    .x(st_a[0]), .y(st_a[1]), .z(st_a[2]),
    .alpha(p_alpha), .beta(p_beta), .m0(p_m0), .m1(p_m1),
    .dx(dx), .dy(dy), .dz(dz), .ovf(deriv_ovf)
  );

  chaos_integ #(.W(W), .LANES(LANES), .SHIFT(DT_SHIFT)) u_integ (
    .clk(clk), .rst_n(rst_n), .load(key_load), .adv(accept),
    .init_v(init_a), .rate_v(rate_a), .state_v(st_a), .ovf(integ_ovf)
  );

  assign x_out     = st_a[0];
  assign y_out     = st_a[1];
  assign z_out     = st_a[2];
  assign out_valid = vld;
  assign sat_flag  = flag;

  AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> (x_out == $past(key_x0)) && (y_out == $past(key_y0)) &&
                 (z_out == $past(key_z0)) && !out_valid && !sat_flag); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !key_load |=> sat_flag); // R6

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !out_valid && !key_load |=> out_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !key_load |=>
      out_valid && $stable(x_out) && $stable(y_out) && $stable(z_out)); // R8

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !step_en && !key_load |=> !out_valid); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en && !key_load |=> $stable(x_out) && $stable(y_out) && $stable(z_out)); // R10
endmodule

// File: tb/chaos_euler_core_test.sv
module chaos_euler_core_test;
  localparam longint ONE  = 64'sd33554432;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;
  localparam real    SCL  = 33554432.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_load = 1'b0, step_en = 1'b0, out_ready = 1'b0;
  logic signed [31:0] key_x0, key_y0, key_z0, key_alpha, key_beta, key_m0, key_m1;
  logic out_valid, sat_flag;
  logic signed [31:0] x_out, y_out, z_out;

  longint k_x0, k_y0, k_z0, k_al, k_be, k_m0, k_m1;
  longint mx, my, mz, ma, mb, mm0, mm1;
  bit mv, mf, step_ovf;
  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign key_x0 = 32'(k_x0);
  assign key_y0 = 32'(k_y0);
  assign key_z0 = 32'(k_z0);
  assign key_alpha = 32'(k_al);
  assign key_beta = 32'(k_be);
  assign key_m0 = 32'(k_m0);
  assign key_m1 = 32'(k_m1);

  always #2 clk = ~clk;

  chaos_euler_core uut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load),
    .key_x0(key_x0), .key_y0(key_y0), .key_z0(key_z0),
    .key_alpha(key_alpha), .key_beta(key_beta), .key_m0(key_m0), .key_m1(key_m1),
    .step_en(step_en), .out_ready(out_ready), .out_valid(out_valid),
    .x_out(x_out), .y_out(y_out), .z_out(z_out), .sat_flag(sat_flag)
  );

  function automatic longint fx(input real r);
    return longint'($rtoi(r * SCL));
  endfunction

  function automatic longint clamp(input longint v);
    if (v > MAXV) begin step_ovf = 1'b1; return MAXV; end
    if (v < MINV) begin step_ovf = 1'b1; return MINV; end
    return v;
  endfunction

  function automatic longint qmul(input longint a, input longint b);
    return clamp((a * b) >>> 25);
  endfunction

  task automatic model_cycle(input bit ld, input bit en, input bit rdy);
    longint f, gap, ddx, ddy, ddz;
    if (ld) begin
      mx = k_x0; my = k_y0; mz = k_z0;
      ma = k_al; mb = k_be; mm0 = k_m0; mm1 = k_m1;
      mv = 1'b0; mf = 1'b0;
    end else if (en && (!mv || rdy)) begin
      step_ovf = 1'b0;
      if (mx > ONE) begin
        gap = clamp(mm0 - mm1);
        f = clamp(qmul(mm1, mx) + gap);
      end else if (mx < -ONE) begin
        gap = clamp(mm0 - mm1);
        f = clamp(qmul(mm1, mx) - gap);
      end else begin
        f = qmul(mm0, mx);
      end
      ddx = qmul(ma, clamp(clamp(my - mx) - f));
      ddy = clamp(clamp(mx - my) + mz);
      ddz = clamp(0 - qmul(mb, my));
      mx = clamp(mx + (ddx >>> 7));
      my = clamp(my + (ddy >>> 7));
      mz = clamp(mz + (ddz >>> 7));
      mv = 1'b1;
      if (step_ovf) mf = 1'b1;
    end else if (mv && rdy) begin
      mv = 1'b0;
    end
  endtask

  task automatic check_model(input string tag);
    checks++;
    if (out_valid !== mv || sat_flag !== mf || longint'(x_out) != mx ||
        longint'(y_out) != my || longint'(z_out) != mz) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b x=%0d y=%0d z=%0d exp v=%0b f=%0b x=%0d y=%0d z=%0d",
               tag, out_valid, sat_flag, x_out, y_out, z_out, mv, mf, mx, my, mz);
    end
  endtask

  task automatic expect_val(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input bit ld, input bit en, input bit rdy, input string tag);
    key_load = ld; step_en = en; out_ready = rdy;
    model_cycle(ld, en, rdy);
    @(posedge clk);
    #1;
    check_model(tag);
  endtask

  task automatic set_key(input longint x0, input longint y0, input longint z0,
                         input longint al, input longint be, input longint m0, input longint m1);
    k_x0 = x0; k_y0 = y0; k_z0 = z0; k_al = al; k_be = be; k_m0 = m0; k_m1 = m1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    set_key(0, 0, 0, 0, 0, 0, 0);
    mx = 0; my = 0; mz = 0; ma = 0; mb = 0; mm0 = 0; mm1 = 0; mv = 0; mf = 0;
    repeat (3) @(posedge clk);
    #1;
    check_model("R1 reset state");
    rst_n = 1'b1;

    // R2: load together with a step request; load must win
    set_key(fx(0.9654454), fx(1.0029554), fx(1.4597855),
            fx(15.6), fx(-36.0), fx(-9.0/7.0), fx(-4.0/7.0));
    tick(1, 1, 1, "R2 load over step");
    expect_val("R2 x0 loaded", longint'(x_out), k_x0);

    // R5/R6: long free run on the default key
    for (int i = 0; i < 10000; i++) tick(0, 1, 1, "R5 default trajectory");

    // R7..R10: double-scroll key with pseudo-random handshake
    set_key(fx(0.7), fx(0.0), fx(0.0), fx(15.6), fx(28.0), fx(-8.0/7.0), fx(-5.0/7.0));
    tick(1, 0, 0, "R2 reload");
    for (int i = 0; i < 5000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(0, lfsr[0] | lfsr[7], lfsr[3] | lfsr[9], "R8 random handshake");
    end

    // R7/R8/R9/R10 targeted
    tick(1, 0, 0, "R2 reload");
    tick(0, 1, 0, "R7 step");
    expect_val("R7 valid after step", longint'(out_valid), 1);
    tick(0, 1, 0, "R8 stall");
    tick(0, 1, 0, "R8 stall");
    expect_val("R8 valid held", longint'(out_valid), 1);
    tick(0, 1, 1, "R7 step with handshake");
    expect_val("R7 valid kept", longint'(out_valid), 1);
    tick(0, 0, 1, "R9 drain");
    expect_val("R9 valid dropped", longint'(out_valid), 0);
    tick(0, 0, 1, "R10 idle");
    tick(0, 0, 0, "R10 idle");

    // R3: shift rounds toward minus infinity
    set_key(0, 1, 0, ONE, 0, 0, 0);
    tick(1, 0, 0, "R3 load");
    tick(0, 1, 1, "R3 floor positive");
    expect_val("R3 x after +1 lsb", longint'(x_out), 0);
    expect_val("R3 y after -1 lsb", longint'(y_out), 0);
    set_key(0, -1, 0, ONE, 0, 0, 0);
    tick(1, 0, 0, "R3 load");
    tick(0, 1, 1, "R3 floor negative");
    expect_val("R3 x floor", longint'(x_out), -1);
    expect_val("R3 y floor", longint'(y_out), -1);

    // R5: hand-computed step, upper segment
    set_key(2 * ONE, ONE, 0, ONE, ONE, ONE / 2, ONE / 4);
    tick(1, 0, 0, "R5 load");
    tick(0, 1, 1, "R5 hand step");
    expect_val("R5 x", longint'(x_out), 66650112);
    expect_val("R5 y", longint'(y_out), 33816576);
    expect_val("R5 z", longint'(z_out), -262144);

    // R4: lower and middle segments, and edges
    set_key(-2 * ONE, 0, 0, ONE, 0, ONE / 2, ONE / 4);
    tick(1, 0, 0, "R4 load");
    tick(0, 1, 1, "R4 low segment");
    expect_val("R4 low x", longint'(x_out), -66387968);
    set_key(ONE / 2, 0, 0, ONE, 0, ONE / 2, ONE / 4);
    tick(1, 0, 0, "R4 load");
    tick(0, 1, 1, "R4 mid segment");
    expect_val("R4 mid x", longint'(x_out), 16580608);
    set_key(ONE + 1, 0, 0, ONE, 0, fx(-9.0/7.0), fx(-4.0/7.0));
    tick(1, 0, 0, "R4 load");
    tick(0, 1, 1, "R4 above +1");
    set_key(-ONE - 1, 0, 0, ONE, 0, fx(-9.0/7.0), fx(-4.0/7.0));
    tick(1, 0, 0, "R4 load");
    tick(0, 1, 1, "R4 below -1");
    set_key(-ONE, 0, 0, ONE, 0, fx(-9.0/7.0), fx(-4.0/7.0));
    tick(1, 0, 0, "R4 load");
    tick(0, 1, 1, "R4 at -1");

    // R6: forced clamp, sticky, cleared by load
    set_key(0, 60 * ONE, 0, 60 * ONE, 0, 0, 0);
    tick(1, 0, 0, "R6 load");
    tick(0, 1, 1, "R6 clamp step");
    expect_val("R6 flag set", longint'(sat_flag), 1);
    expect_val("R6 x clamped", longint'(x_out), 16777215);
    tick(0, 0, 1, "R6 sticky");
    tick(0, 0, 0, "R6 sticky");
    expect_val("R6 flag sticky", longint'(sat_flag), 1);
    tick(1, 0, 0, "R6 load clears");
    expect_val("R6 flag cleared", longint'(sat_flag), 0);

    finish_run();
  end
endmodule